// File: doc/BRIEF.md
# Sigma-Delta Bitstream Averaging Decimator

This block turns the one-bit output of a sigma-delta modulator into multibit samples. The information sits in the density of ones, so the block counts how many ones arrive inside a window of `WIN_LEN` accepted bits. The count is the output word, and word / `WIN_LEN` is the mean of the stream. With `WIN_LEN` = 16, seven ones give the word 7, which reads as 0.4375. A longer window lowers the cutoff of this boxcar low-pass and adds delay.

Two modes are selected by the `mode_slide` pin. In block mode, windows do not overlap, so one word is produced for every `WIN_LEN` accepted bits. In sliding mode, a history line of `WIN_LEN` bits keeps the running count current: the count adds the arriving bit and drops the bit that leaves the window. A word is then produced for every accepted bit. In both modes, no word appears until the first full window after reset has been collected. The mode pin is meant to be changed only while reset is held.

Top module: `bitstream_boxcar_decimator`

## Requirements
- R1: In block mode (`mode_slide`=0), `word_vld` is high for exactly one clock, the cycle after the clock that accepted the `WIN_LEN`-th bit of a window. `word_out` then holds the number of ones among that window's bits. The next accepted bit starts a new, non-overlapping window from a count of zero.
- R2: In block mode, exactly one word is produced per `WIN_LEN` accepted bits, and `word_vld` is never high in two consecutive cycles.
- R3: `word_out` is $clog2(`WIN_LEN`)+1 bits wide, unsigned. A window of all ones yields `WIN_LEN` (16 = 5'b10000 by default). A window of all zeros yields 0. The word never exceeds `WIN_LEN`.
- R4: A clock with `bit_vld`=0 is ignored, whatever `bit_in` holds. It changes neither the count, nor the window position, nor the history, and it produces no word.
- R5: In sliding mode (`mode_slide`=1), every accepted bit from the `WIN_LEN`-th one after reset onward gives `word_vld` high in the next cycle. `word_out` then equals the number of ones among the most recent `WIN_LEN` accepted bits.
- R6: In either mode, `word_vld` stays low until `WIN_LEN` bits have been accepted since reset.
- R7: While the synchronous active-high `rst` is high, and in the first cycle after it is released, `word_vld` is 0 and `word_out` is 0. Reset clears the count, the window position and the history, so bits accepted before reset never contribute to a later word.
- R8: In sliding mode, two words produced in consecutive cycles differ by at most 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_slide | input | 1 | 0 = block windows, 1 = sliding window; change only during reset |
| bit_in | input | 1 | Modulator bit |
| bit_vld | input | 1 | Qualifies `bit_in` in this cycle |
| word_out | output | $clog2(WIN_LEN)+1 | Count of ones in the window (registered) |
| word_vld | output | 1 | `word_out` carries a new word this cycle (registered) |

## Verification
In block mode, the clock that closes one window also starts the next one. The emitted word and the restart of the count from zero fall on the same edge. The bench provokes this by streaming bits back to back with no idle cycles, so that the first bit of each window arrives right after the closing bit. Each word is judged against a model sum of only that window's bits. In sliding mode, the arriving bit and the bit leaving the window are added and removed on the same edge. Pseudo-random streams put a one in both places at once, and the scoreboard compares every word with a model that keeps the last `WIN_LEN` accepted bits.

// File: rtl/bbd_pkg.sv
package bbd_pkg;
  typedef enum logic {
    AVG_BLOCK = 1'b0,
    AVG_SLIDE = 1'b1
  } avg_mode_e;

  // output width: enough to hold a count equal to the window length
  function automatic int word_bits(input int win);
    return $clog2(win) + 1;
  endfunction
endpackage

// File: rtl/bbd_history.sv
module bbd_history #(
  parameter int WIN_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic bit_in,
  output logic bit_old
);
  logic [WIN_LEN-1:0] line;

  generate
    if (WIN_LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           line <= '0;
        else if (shift_en) line <= bit_in;
      end
    end else begin : g_line
      always_ff @(posedge clk) begin
        if (rst)           line <= '0;
        else if (shift_en) line <= {line[WIN_LEN-2:0], bit_in};
      end
    end
  endgenerate

  // bit about to leave the window when the next bit is shifted in
  assign bit_old = line[WIN_LEN-1];
endmodule

// File: rtl/bbd_accum.sv
module bbd_accum
  import bbd_pkg::*;
#(
  parameter int WIN_LEN = 16,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  avg_mode_e     mode,
  input  logic          bit_vld,
  input  logic          bit_new,
  input  logic          bit_old,
  output logic          emit,
  output logic [CW-1:0] total
);
  localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(WIN_LEN - 1);

  logic [PW-1:0] pos;
  logic          full;
  logic [CW-1:0] cnt;
  logic          drop;
  logic          wrap;

  always_comb begin
    drop  = (mode == AVG_SLIDE) && bit_old;
    total = cnt + CW'(bit_new) - CW'(drop);
    wrap  = (pos == LAST);
    emit  = bit_vld && (wrap || ((mode == AVG_SLIDE) && full));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      full <= 1'b0;
      cnt  <= '0;
    end else if (bit_vld) begin
      pos <= wrap ? '0 : pos + PW'(1);
      if (wrap) full <= 1'b1;
      cnt <= ((mode == AVG_BLOCK) && wrap) ? '0 : total;
    end
  end

  // R3: the running count never exceeds the window length
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(WIN_LEN));

  // R4: idle cycles leave the count untouched
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(cnt));
endmodule

// File: rtl/bitstream_boxcar_decimator.sv
module bitstream_boxcar_decimator
  import bbd_pkg::*;
#(
  parameter int WIN_LEN = 16,
  localparam int CW     = bbd_pkg::word_bits(WIN_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_slide,
  input  logic          bit_in,
  input  logic          bit_vld,
  output logic [CW-1:0] word_out,
  output logic          word_vld
);
  avg_mode_e     mode;
  logic          bit_old;
  logic          emit;
  logic [CW-1:0] total;

  assign mode = mode_slide ? AVG_SLIDE : AVG_BLOCK;

  bbd_history #(.WIN_LEN(WIN_LEN)) u_history (
    .clk      (clk),
    .rst      (rst),
    .shift_en (bit_vld),
    .bit_in   (bit_in),
    .bit_old  (bit_old)
  );

  bbd_accum #(.WIN_LEN(WIN_LEN), .CW(CW)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .bit_vld (bit_vld),
    .bit_new (bit_in),
    .bit_old (bit_old),
    .emit    (emit),
    .total   (total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= emit;
      if (emit) word_out <= total;
    end
  end

  // R3: a published word fits the window length
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (word_out <= CW'(WIN_LEN)));

  // R2: block windows never yield back-to-back words
  a_r2_block_spacing: assert property (@(posedge clk) disable iff (rst)
    (!mode_slide && word_vld) |=> !word_vld);

  // R4: every word is caused by an accepted bit one cycle earlier
  a_r4_word_cause: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(bit_vld));

  // R7: nothing is published in the cycle after reset
  a_r7_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!word_vld && word_out == '0));

  // R8: sliding words move by at most one step
  a_r8_slide_step: assert property (@(posedge clk) disable iff (rst)
    (mode_slide && word_vld && $past(word_vld)) |->
      ((word_out == $past(word_out)) ||
       (word_out == $past(word_out) + CW'(1)) ||
       (word_out + CW'(1) == $past(word_out))));
endmodule

// File: tb/test_bitstream_boxcar_decimator.sv
module test_bitstream_boxcar_decimator;
  localparam int WIN        = 16;
  localparam int CW         = $clog2(WIN) + 1;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst = 1'b1, mode_slide = 1'b0, bit_in = 1'b0, bit_vld = 1'b0;
  logic [CW-1:0] word_out;
  logic word_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitstream_boxcar_decimator #(.WIN_LEN(WIN)) i_bitstream_boxcar_decimator (
    .clk(clk), .rst(rst), .mode_slide(mode_slide), .bit_in(bit_in),
    .bit_vld(bit_vld), .word_out(word_out), .word_vld(word_vld));

  int cyc = 0, checks = 0, errors = 0, words_seen = 0;
  bit done = 0;
  int exp_val[$];
  int exp_due[$];
  string exp_tag[$];
  int m_hist[$];
  int m_valid = 0, m_sum = 0;
  logic prev_vld = 0;
  int prev_word = 0;
  logic [7:0] lf = 8'hA5;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: one accepted bit, model update, expected word queued
  task automatic send(input logic b, input string tag);
    @(negedge clk); #1;
    bit_vld = 1'b1; bit_in = b;
    m_valid++;
    if (mode_slide) begin
      m_hist.push_back(int'(b));
      if (m_hist.size() > WIN) void'(m_hist.pop_front());
      if (m_valid >= WIN) begin
        int s = 0;
        foreach (m_hist[k]) s += m_hist[k];
        exp_val.push_back(s); exp_due.push_back(cyc + 1); exp_tag.push_back(tag);
      end
    end else begin
      m_sum += int'(b);
      if (m_valid % WIN == 0) begin
        exp_val.push_back(m_sum); exp_due.push_back(cyc + 1); exp_tag.push_back(tag);
        m_sum = 0;
      end
    end
  endtask

  task automatic gap(input logic junk);
    @(negedge clk); #1;
    bit_vld = 1'b0; bit_in = junk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) gap(1'b1);
  endtask

  task automatic lfsr_bit(output logic b);
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    b = lf[0];
  endtask

  task automatic do_reset(input logic slide);
    @(negedge clk); #1;
    rst = 1'b1; bit_vld = 1'b0; mode_slide = slide;
    repeat (3) @(negedge clk);
    check(word_vld == 1'b0, "R7 word_vld in reset", int'(word_vld), 0);
    check(word_out == '0, "R7 word_out in reset", int'(word_out), 0);
    #1 rst = 1'b0;
    m_hist.delete(); m_valid = 0; m_sum = 0;
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst) begin
      while (exp_due.size() > 0 && exp_due[0] < cyc) begin
        check(1'b0, {exp_tag[0], " missing word"}, 0, exp_val[0]);
        void'(exp_val.pop_front()); void'(exp_due.pop_front()); void'(exp_tag.pop_front());
      end
      if (word_vld) begin
        words_seen++;
        if (exp_due.size() == 0 || exp_due[0] != cyc) begin
          check(1'b0, "R6 unexpected word", int'(word_out), -1);
        end else begin
          check(int'(word_out) == exp_val[0], exp_tag[0], int'(word_out), exp_val[0]);
          void'(exp_val.pop_front()); void'(exp_due.pop_front()); void'(exp_tag.pop_front());
        end
        if (!mode_slide)
          check(!prev_vld, "R2 back-to-back block words", int'(prev_vld), 0);
        else if (prev_vld)
          check((int'(word_out) - prev_word <= 1) && (prev_word - int'(word_out) <= 1),
                "R8 sliding step", int'(word_out), prev_word);
        prev_word = int'(word_out);
      end
      prev_vld = word_vld;
    end else begin
      prev_vld = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (cyc == WATCHDOG && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b;
    int seen0;
    do_reset(1'b0);
    // R1: seven ones in one window -> 7 (0.4375)
    for (int i = 0; i < WIN; i++) send((i % 2 == 0) && (i < 14), "R1 seven ones");
    // R3: extremes
    for (int i = 0; i < WIN; i++) send(1'b1, "R3 all ones");
    for (int i = 0; i < WIN; i++) send(1'b0, "R3 all zeros");
    // R4: gaps carrying ones are ignored
    for (int i = 0; i < WIN; i++) begin send(1'b0, "R4 gaps ignored"); gap(1'b1); end
    for (int i = 0; i < WIN; i++) begin send(1'b1, "R4 gaps with ones"); gap(1'b0); gap(1'b1); end
    // R2/R1: back-to-back windows, pseudo-random
    for (int i = 0; i < 3 * WIN; i++) begin lfsr_bit(b); send(b, "R2 streaming windows"); end
    // R7: partial window of ones cleared by reset
    for (int i = 0; i < 10; i++) send(1'b1, "R7 partial");
    idle(3);
    do_reset(1'b0);
    for (int i = 0; i < WIN; i++) send(1'b0, "R7 block after reset");
    idle(3);
    // sliding mode
    do_reset(1'b1);
    seen0 = words_seen;
    for (int i = 0; i < WIN - 1; i++) send(1'b1, "R6 early");
    idle(2);
    check(words_seen == seen0, "R6 no word before full window", words_seen - seen0, 0);
    for (int i = 0; i < 60; i++) begin
      lfsr_bit(b); send(b, "R5 sliding random");
      if (i % 7 == 3) gap(~b);
    end
    for (int i = 0; i < WIN; i++) send(1'b1, "R5 sliding rise");
    for (int i = 0; i < WIN; i++) send(1'b0, "R5 sliding fall");
    for (int i = 0; i < WIN; i++) send(1'b1, "R5 sliding refill");
    idle(3);
    do_reset(1'b1);
    for (int i = 0; i < 2 * WIN; i++) send(1'b0, "R7 sliding history cleared");
    idle(4);
    check(exp_val.size() == 0, "R1 scoreboard drained", exp_val.size(), 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule